// File: doc/BRIEF.md
# Low-Power Clock Enable Divider with Fast Wake

This block produces the system clock enable for a processor core from a free-running oscillator. At full rate the enable is high on every oscillator cycle. When software sets the low-power bit, the enable instead pulses once every 256 oscillator cycles, so all logic qualified by it runs at 1/256 of the normal rate. Clearing the bit returns the core to full rate at once.

Software writes both control bits, low-power and fast-wake, with one write strobe. A request to enter low-power mode is refused while a serial port (USART or SPI) is moving data or an external interrupt is waiting. In that case the write leaves the bit clear, and software can read it back to see that the request failed. When the fast-wake bit is set and serial traffic or an interrupt appears during low-power mode, the block drops back to full rate on its own. The readable low-power bit then shows that this happened.

Top module: `pm_clkdiv`

## Requirements
- R1: A write with `wr_lp_mode`=1, while `ser_busy` and `irq_pend` are both 0, sets `lp_mode` to 1 on the clock edge that takes the write.
- R2: While `lp_mode` is 1, `sys_ce` is high for exactly one cycle in every 256. The first pulse is in the 256th cycle after the entry edge. The cycle right after the entry edge counts as cycle 1.
- R3: While `lp_mode` is 0, `sys_ce` is high on every cycle. A write with `wr_lp_mode`=0 clears `lp_mode`, and `sys_ce` is high from the first cycle after that edge.
- R4: Reset (`rst_n`=0) clears `lp_mode` and `fast_wake`, so `sys_ce` is high.
- R5: A write with `wr_lp_mode`=1 while `ser_busy` or `irq_pend` is 1 has no effect on a clear `lp_mode`, which reads 0 afterwards.
- R6: Every write loads `wr_fast_wake` into `fast_wake`, and `fast_wake` can be read back.
- R7: While `fast_wake` is 1 and `lp_mode` is 1, a high `ser_busy` or `irq_pend` clears `lp_mode` on the next edge, and `sys_ce` is high in the following cycle.
- R8: While `fast_wake` is 0, `ser_busy` or `irq_pend` during low-power mode does not clear `lp_mode` and does not disturb the 1-in-256 pulse pattern.
- R9: Leaving low-power mode mid-period discards the partial count. The next entry again gives its first pulse in the 256th cycle after the entry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_lp_mode | input | 1 | Value written to the low-power bit |
| wr_fast_wake | input | 1 | Value written to the fast-wake bit |
| ser_busy | input | 1 | A serial port is transmitting or receiving |
| irq_pend | input | 1 | An external interrupt awaits service |
| sys_ce | output | 1 | System clock enable |
| lp_mode | output | 1 | Low-power bit, readable state |
| fast_wake | output | 1 | Fast-wake bit, readable state |

## Verification
The assertions assume that `ser_busy` and `irq_pend` are synchronous to `clk` and stable around the edge. They also assume that a write lasts exactly one cycle, so each strobe is one control access. The bench drives every input on the falling edge and raises `wr_en` for one cycle per write. It sweeps the busy and pending combinations for both the refused entry and the fast-wake exit. It then compares every enable cycle against a cycle count kept in the bench since the last entry.

// File: rtl/pm_clkdiv.sv
module pm_clkdiv #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_lp_mode,
  input  logic wr_fast_wake,
  input  logic ser_busy,
  input  logic irq_pend,
  output logic sys_ce,
  output logic lp_mode,
  output logic fast_wake
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          blocked;
  logic          wake_trip;

  assign blocked   = ser_busy | irq_pend;
  assign wake_trip = fast_wake & lp_mode & blocked;
  assign sys_ce    = ~lp_mode | (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_mode   <= 1'b0;
      fast_wake <= 1'b0;
    end else begin
      if (wr_en) fast_wake <= wr_fast_wake;
      if (wake_trip)
        lp_mode <= 1'b0;
      else if (wr_en) begin
        if (!wr_lp_mode)   lp_mode <= 1'b0;
        else if (!blocked) lp_mode <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lp_mode || cnt == LAST) cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lp_mode && !ser_busy && !irq_pend) |=> lp_mode);

  p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_mode) |-> !sys_ce);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && sys_ce) |=> (!sys_ce || !lp_mode));

  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode |-> sys_ce);

  p_write_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_lp_mode) |=> (!lp_mode && sys_ce));

  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_mode && (ser_busy || irq_pend)) |=> !lp_mode);

  p_wake_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fast_wake == $past(wr_fast_wake)));

  p_fast_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_wake && lp_mode && (ser_busy || irq_pend)) |=> (!lp_mode && sys_ce));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !fast_wake && !wr_en) |=> lp_mode);
endmodule

// File: tb/pm_clkdiv_bench.sv
module pm_clkdiv_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_lp_mode = 1'b0, wr_fast_wake = 1'b0;
  logic ser_busy = 1'b0, irq_pend = 1'b0;
  logic sys_ce, lp_mode, fast_wake;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pm_clkdiv u_pm_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lp_mode(wr_lp_mode),
    .wr_fast_wake(wr_fast_wake), .ser_busy(ser_busy), .irq_pend(irq_pend),
    .sys_ce(sys_ce), .lp_mode(lp_mode), .fast_wake(fast_wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic lp, input logic fw);
    @(negedge clk);
    wr_en = 1'b1; wr_lp_mode = lp; wr_fast_wake = fw;
    @(negedge clk);
    wr_en = 1'b0;
    k = 1;
  endtask

  task automatic run_slow(input int n, input string tag);
    int bad = 0;
    if (sys_ce != ((k % 256) == 0) || !lp_mode) bad++;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k++;
      if (sys_ce != ((k % 256) == 0) || !lp_mode) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic run_fast(input int n, input string tag);
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_ce) ones++;
    end
    chk(tag, ones, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 lp_mode after reset", lp_mode, 0);
    chk("R4 fast_wake after reset", fast_wake, 0);
    chk("R4 sys_ce after reset", sys_ce, 1);
    rst_n = 1'b1;
    run_fast(20, "R3 full rate idle");

    for (int c = 1; c < 4; c++) begin
      @(negedge clk);
      ser_busy = c[0]; irq_pend = c[1];
      wr(1'b1, 1'b0);
      chk($sformatf("R5 refused set busy=%0d pend=%0d", c[0], c[1]), lp_mode, 0);
      chk("R5 refused set keeps full rate", sys_ce, 1);
      ser_busy = 1'b0; irq_pend = 1'b0;
    end

    wr(1'b1, 1'b0);
    chk("R1 set accepted", lp_mode, 1);
    run_slow(800, "R2 one pulse per 256 cycles");
    begin
      int pulses = 0;
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        k++;
        if (sys_ce) pulses++;
      end
      chk("R2 pulse count over 512 cycles", pulses, 2);
    end

    for (int c = 1; c < 4; c++) begin
      @(negedge clk);
      k++;
      ser_busy = c[0]; irq_pend = c[1];
      run_slow(300, "R8 no exit with fast_wake clear");
      ser_busy = 1'b0; irq_pend = 1'b0;
    end

    run_slow(37, "R2 before mid-period exit");
    wr(1'b0, 1'b0);
    chk("R3 exit clears lp_mode", lp_mode, 0);
    chk("R3 enable high after exit", sys_ce, 1);
    run_fast(10, "R3 full rate after exit");

    wr(1'b1, 1'b0);
    chk("R9 re-entry accepted", lp_mode, 1);
    run_slow(256, "R9 first pulse after re-entry at 256");
    run_slow(99, "R9 partial period");
    wr(1'b0, 1'b1);
    chk("R6 fast_wake loaded", fast_wake, 1);
    chk("R3 exit with fast_wake write", lp_mode, 0);

    for (int c = 1; c < 4; c++) begin
      wr(1'b1, 1'b1);
      chk("R1 entry with fast_wake", lp_mode, 1);
      run_slow(50, "R2 slow before fast wake");
      ser_busy = c[0]; irq_pend = c[1];
      @(negedge clk);
      chk($sformatf("R7 fast exit busy=%0d pend=%0d", c[0], c[1]), lp_mode, 0);
      chk("R7 enable high after fast exit", sys_ce, 1);
      ser_busy = 1'b0; irq_pend = 1'b0;
      run_fast(5, "R7 full rate after fast exit");
    end

    wr(1'b0, 1'b0);
    chk("R6 fast_wake cleared by write", fast_wake, 0);
    wr(1'b1, 1'b1);
    run_slow(10, "R2 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk("R4 reset clears lp_mode", lp_mode, 0);
    chk("R4 reset clears fast_wake", fast_wake, 0);
    chk("R4 reset restores full rate", sys_ce, 1);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #2000000;
    join_any
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule